// File: doc/BRIEF.md
# Scan Chain with Frozen Functional Outputs

This block is a serial test chain of single-bit storage stages. Each stage has two registers. A capture register is a multiplexed scan flip-flop: in functional mode it loads its own bit of the functional input vector, and in shift mode it loads the bit arriving from the stage before it. A hold register sits between the capture register and the logic it feeds. When the hold control is low, the hold register follows the capture register one clock later. When the hold control is high, the hold register keeps its value.

The serial path runs from capture register to capture register and never passes through a hold register. A full pattern can therefore be shifted in and out while the hold control is high, and the outputs that drive downstream logic do not toggle during the shift. This cuts switching power in that logic during scan. When the hold control is released, the downstream logic sees the captured or shifted pattern on the next clock edge.

Top module: `shold_chain`

## Requirements
- R1: An active-low reset clears every capture register and every hold register to 0, so `func_q` and `scan_out` read 0.
- R2: When `test_en` is 0, each clock edge loads capture register i with `func_d[i]`.
- R3: When `test_en` is 1, each clock edge loads capture register 0 with `scan_in` and capture register i with the previous value of capture register i-1. The source is the capture register, not its hold register, so data moves from index 0 toward index WIDTH-1.
- R4: `scan_out` always equals capture register WIDTH-1.
- R5: While `hold` is 1 at a clock edge, `func_q` keeps the value it had before that edge.
- R6: When `hold` is 0 at a clock edge, `func_q[i]` takes the value capture register i held before that edge. A captured value therefore appears on `func_q` one edge after it is captured.
- R7: A full WIDTH-bit shift performed with `hold` at 1 leaves `func_q` unchanged on every cycle. During the shift, `scan_out` presents the previously captured bits, highest index first.
- R8: With `hold` at 1 and `test_en` at 0, the capture registers still load `func_d` while `func_q` stays frozen. Releasing `hold` then brings the captured word to `func_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| test_en | input | 1 | 1 selects the serial input of every stage, 0 selects the functional input |
| scan_in | input | 1 | Serial data into stage 0 |
| hold | input | 1 | 1 freezes all hold registers |
| func_d | input | WIDTH | Functional data into the capture registers |
| func_q | output | WIDTH | Hold register outputs that feed the downstream logic |
| scan_out | output | 1 | Serial data out of the last stage |

## Verification
The hardest situation to create is a capture register and its hold register holding different values while a shift is in progress. The only way to observe it at the ports is for `func_q` to show the old word while `scan_out` streams a different word. The stimulus creates this condition for every 4-bit pattern, in three steps:
- It loads a word with `hold` low.
- It raises `hold` and captures the complement of that word.
- It shifts a third word in bit by bit.

At each step the bench checks `func_q` against the first word and `scan_out` against the complement. Releasing `hold` at the end shows whether the shifted word reached the capture registers intact.

// File: rtl/shold_pkg.sv
package shold_pkg;

    typedef enum logic {
        MODE_FUNC  = 1'b0,
        MODE_SHIFT = 1'b1
    } mode_e;

    typedef struct packed {
        logic data;
    } cap_state_t;

    typedef struct packed {
        logic data;
    } hold_state_t;

endpackage

// File: rtl/shold_capture.sv
module shold_capture
    import shold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic test_en,
    input  logic func_bit,
    input  logic serial_bit,
    output logic cap_bit
);
    cap_state_t st_d, st_q;
    mode_e      mode;

    always_comb begin
        mode = mode_e'(test_en);
        st_d = st_q;
        if (mode == MODE_SHIFT) begin
            st_d.data = serial_bit;
        end else begin
            st_d.data = func_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_bit = st_q.data;

    // R2: functional load
    assert_func_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> cap_bit == $past(func_bit));

endmodule

// File: rtl/shold_hold.sv
module shold_hold
    import shold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic src_bit,
    output logic held_bit
);
    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            st_d.data = src_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_bit = st_q.data;

    // R5: frozen while hold is high
    assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(held_bit));

    // R6: follows the capture register one edge later
    assert_hold_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> held_bit == $past(src_bit));

endmodule

// File: rtl/shold_chain.sv
module shold_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_en,
    input  logic             scan_in,
    input  logic             hold,
    input  logic [WIDTH-1:0] func_d,
    output logic [WIDTH-1:0] func_q,
    output logic             scan_out
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] cap_bits;
    logic [WIDTH-1:0] serial_src;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign serial_src[i] = scan_in;
        end else begin : g_link
            assign serial_src[i] = cap_bits[i-1];
        end

        shold_capture u_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .test_en   (test_en),
            .func_bit  (func_d[i]),
            .serial_bit(serial_src[i]),
            .cap_bit   (cap_bits[i])
        );

        shold_hold u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold    (hold),
            .src_bit (cap_bits[i]),
            .held_bit(func_q[i])
        );

        if (i == 0) begin : g_chk_head
            // R3: stage 0 takes the serial input
            assert_shift_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
                test_en |=> cap_bits[0] == $past(scan_in));
        end else begin : g_chk_link
            // R3: stage i takes the capture register of stage i-1
            assert_shift_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
                test_en |=> cap_bits[i] == $past(cap_bits[i-1]));
        end
    end

    assign scan_out = cap_bits[LAST];

    // R7: a shift under hold leaves the functional outputs alone
    assert_shift_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && test_en) |=> func_q == $past(func_q));

endmodule

// File: tb/shold_chain_test.sv
module shold_chain_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_en = 1'b0;
    logic         scan_in = 1'b0;
    logic         hold = 1'b0;
    logic [W-1:0] func_d = '0;
    logic [W-1:0] func_q;
    logic         scan_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shold_chain #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .scan_in(scan_in),
        .hold(hold), .func_d(func_d), .func_q(func_q), .scan_out(scan_out)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] p, q, np;
        rst_n = 1'b0;
        func_d = 4'hF;
        tick();
        tick();
        chk("R1 func_q after reset", func_q, '0);
        chk("R1 scan_out after reset", {3'b0, scan_out}, '0);
        rst_n = 1'b1;

        for (int v = 0; v < 16; v++) begin
            p  = W'(v);
            np = ~p;
            q  = p ^ 4'b1010;

            // functional load, hold low
            hold = 1'b0; test_en = 1'b0; func_d = p;
            tick();
            chk("R4 scan_out after capture", {3'b0, scan_out}, {3'b0, p[W-1]});
            tick();
            chk("R2/R6 func_q after load", func_q, p);

            // hold high, capture the complement
            hold = 1'b1; func_d = np;
            tick();
            chk("R8 func_q frozen during capture", func_q, p);
            chk("R8 scan_out shows new capture", {3'b0, scan_out}, {3'b0, np[W-1]});

            // shift q in under hold
            test_en = 1'b1;
            for (int k = 0; k < W; k++) begin
                scan_in = q[W-1-k];
                tick();
                chk("R5/R7 func_q frozen during shift", func_q, p);
                if (k < W - 1)
                    chk("R3/R7 scan_out stream", {3'b0, scan_out}, {3'b0, np[W-2-k]});
            end

            // release
            test_en = 1'b0; func_d = q; hold = 1'b0;
            tick();
            chk("R6/R3 func_q after release", func_q, q);
        end

        // mid-run reset
        hold = 1'b1; rst_n = 1'b0;
        tick();
        chk("R1 func_q on reset under hold", func_q, '0);
        rst_n = 1'b1; hold = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule